// File: doc/BRIEF.md
# Double-Buffered Audio Sample DMA

This block streams stereo audio from memory. Software queues up to two buffer descriptors, each an address and a byte length, through a small register bus. It also sets an enable, a sample-rate divider and a bit-depth field. Once per sample period the block reads one 32-bit word from memory. It splits the word into a signed left and right 16-bit sample and offers the pair on a valid/ready output.

When the head buffer runs out it is dropped from the queue. The second descriptor, if there is one, becomes the head and an interrupt is raised so software can queue the next buffer. The address steps through an 8 KB window. A wrap of the low part is carried into the upper bits only on the following fetch.

The memory port is a single-outstanding valid/ready request with a response strobe. The sample output follows valid/ready rules: once `smp_valid` is high, the pair stays unchanged until `smp_ready` is seen. A memory request likewise holds its address until `mem_req_ready` is seen. The period counter is frozen for the whole fetch and hand-off, so back-pressure on either side stretches the time between samples and never drops a sample.

Top module: `pcm_out_dma`

## Requirements
- R1: After reset the queue is empty, the enable, rate and depth registers are zero, the interrupt is low, and neither `mem_req_valid` nor `smp_valid` is asserted.
- R2: A write to select 0 stores bits 23:3 of the data as a buffer address, with bits 2:0 forced to zero. It goes into the slot numbered by the current queue count and is ignored when two descriptors are queued.
- R3: A write to select 1 keeps bits 17:3 of the data as a length, with bits 2:0 forced to zero. It queues a descriptor only if fewer than two are queued and the masked length is nonzero. Reading any select other than 3 returns the head's remaining length.
- R4: Reading select 3 returns the status word. Bits 0 and 31 are set when two descriptors are queued. Bit 30 is set when at least one is queued. Bit 25 shows the enable (select 2, data bit 0). Bits 20 and 24 are always one. All other bits are zero.
- R5: Any write to select 3 clears the interrupt.
- R6: Select 4 holds a 14-bit rate. The idle wait between fetches is 2*(rate+1) cycles. With no stalls, handed-off samples are 2*(rate+1)+3 cycles apart.
- R7: Select 5 holds a 4-bit depth. `smp_precision` equals depth+1.
- R8: Each fetched word gives `smp_left` from bits 31:16 and `smp_right` from bits 15:0.
- R9: After each fetch only address bits 12:0 advance by 4. If they wrap to zero, a carry is added to bits 23:13 (modulo 2^11) at the next fetch.
- R10: Each fetch lowers the head length by 4. At zero the descriptor leaves the queue. If a descriptor is still queued afterwards it becomes the head and the interrupt is raised; otherwise the interrupt is left unchanged.
- R11: No memory request is issued while the queue is empty or the enable is clear.
- R12: A stalled memory request keeps its address, and a stalled sample keeps its value, until accepted.
- R13: A length write in the same cycle as the head's last fetch response, with one descriptor queued, becomes the new head and raises the interrupt. Its address is the one previously written into slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the current select |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 24 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Read data word |
| smp_valid | output | 1 | Sample pair is valid |
| smp_ready | input | 1 | Sink takes the sample pair |
| smp_left | output | 16 | Left sample, signed |
| smp_right | output | 16 | Right sample, signed |
| smp_precision | output | 5 | Sample precision, depth+1 |
| irq | output | 1 | Buffer-switch interrupt |

## Verification
The fetch path retires the head descriptor and promotes the second one, while the register bus can queue a descriptor in that same cycle. The two contend for the same slots and the same count. The bench watches its own memory model's response strobe. On the cycle that delivers the head's final word it writes a new length. It then judges the result from the outside: the status count, the head length read back, the interrupt, and the addresses of the samples that follow. The queue-full rejection, the window carry at both bit-13 and bit-23 wraps, and held stalled outputs are checked at the ports as well.

// File: rtl/pcm_dma_pkg.sv
package pcm_dma_pkg;
  typedef enum logic [2:0] {
    RS_ADDR  = 3'd0,
    RS_LEN   = 3'd1,
    RS_EN    = 3'd2,
    RS_STAT  = 3'd3,
    RS_RATE  = 3'd4,
    RS_DEPTH = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_EMIT
  } fetch_st_e;
endpackage

// File: rtl/pcm_rate_timer.sv
module pcm_rate_timer #(
  parameter int RATE_W = 14,
  localparam int CNT_W = RATE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt;

  // idle wait is twice (rate + 1) cycles
  assign period = (CNT_W'(rate) + CNT_W'(1)) << 1;
  assign tick   = run && (cnt >= period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pcm_desc_queue.sv
module pcm_desc_queue #(
  parameter int AW    = 24,
  parameter int LW    = 18,
  parameter int WIN_W = 13,
  localparam int HI_W = AW - WIN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic [AW-1:0] addr_val,
  input  logic          wr_len,
  input  logic [LW-1:0] len_val,
  input  logic          adv,
  output logic [1:0]    count,
  output logic [AW-1:0] fetch_addr,
  output logic [LW-1:0] head_len,
  output logic          pop_raise
);
  logic [AW-1:0] addr0, addr1, a0_n, a1_n;
  logic [LW-1:0] len0, len1, l0_n, l1_n;
  logic          carry, c_n;
  logic [1:0]    cnt_n;
  logic          can_take, enq, pop;
  logic [HI_W-1:0]  hi_fix;
  logic [WIN_W-1:0] lo_n;

  assign can_take   = (count < 2'd2);
  assign enq        = wr_len && can_take && (len_val != '0);
  assign pop        = adv && (len0 == LW'(4));
  assign hi_fix     = addr0[AW-1:WIN_W] + HI_W'(carry);
  assign fetch_addr = {hi_fix, addr0[WIN_W-1:0]};
  assign head_len   = len0;
  assign lo_n       = addr0[WIN_W-1:0] + WIN_W'(4);

  always_comb begin
    a0_n = addr0; a1_n = addr1;
    l0_n = len0;  l1_n = len1;
    c_n  = carry;
    if (adv) begin
      a0_n = {hi_fix, lo_n};
      c_n  = (lo_n == '0);
      l0_n = len0 - LW'(4);
    end
    if (wr_addr && can_take) begin
      if (count == 2'd0) a0_n = addr_val;
      else               a1_n = addr_val;
    end
    if (enq) begin
      if (count == 2'd0) l0_n = len_val;
      else               l1_n = len_val;
    end
    cnt_n     = count + {1'b0, enq} - {1'b0, pop};
    pop_raise = pop && (cnt_n != 2'd0);
    if (pop_raise) begin
      a0_n = a1_n;
      l0_n = l1_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr0 <= '0; addr1 <= '0;
      len0  <= '0; len1  <= '0;
      carry <= 1'b0;
      count <= 2'd0;
    end else begin
      addr0 <= a0_n; addr1 <= a1_n;
      len0  <= l0_n; len1  <= l1_n;
      carry <= c_n;
      count <= cnt_n;
    end
  end

  p_head_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count != 2'd0) |-> (len0 != '0));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 2'd2) |=> (count != 2'd0) && (count <= 2'd2));
endmodule

// File: rtl/pcm_out_dma.sv
module pcm_out_dma
  import pcm_dma_pkg::*;
#(
  parameter int RATE_W  = 14,
  parameter int DEPTH_W = 4,
  parameter int AW      = 24,
  parameter int LW      = 18,
  parameter int WIN_W   = 13,
  parameter int SMP_W   = 16,
  localparam int DW     = 2 * SMP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [2:0]         bus_sel,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [AW-1:0]      mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [DW-1:0]      mem_rsp_data,
  output logic               smp_valid,
  input  logic               smp_ready,
  output logic [SMP_W-1:0]   smp_left,
  output logic [SMP_W-1:0]   smp_right,
  output logic [DEPTH_W:0]   smp_precision,
  output logic               irq
);
  fetch_st_e state;
  logic              en_q;
  logic [RATE_W-1:0] rate_q;
  logic [DEPTH_W-1:0] depth_q;
  logic [SMP_W-1:0]  left_q, right_q;
  logic              tick, go, adv, pop_raise;
  logic [1:0]        q_count;
  logic [LW-1:0]     head_len;
  logic [AW-1:0]     addr_masked;
  logic [LW-1:0]     len_masked;
  logic [31:0]       status;
  logic              wr_stat;

  assign addr_masked = {bus_wdata[AW-1:3], 3'b000};
  assign len_masked  = {bus_wdata[LW-1:3], 3'b000};
  assign wr_stat     = bus_wr && (bus_sel == RS_STAT);

  pcm_rate_timer #(.RATE_W(RATE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_IDLE), .rate(rate_q), .tick(tick)
  );

  assign adv = (state == ST_WAIT) && mem_rsp_valid;

  pcm_desc_queue #(.AW(AW), .LW(LW), .WIN_W(WIN_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .wr_addr(bus_wr && (bus_sel == RS_ADDR)), .addr_val(addr_masked),
    .wr_len(bus_wr && (bus_sel == RS_LEN)), .len_val(len_masked),
    .adv(adv), .count(q_count), .fetch_addr(mem_req_addr),
    .head_len(head_len), .pop_raise(pop_raise)
  );

  assign go = tick && en_q && (q_count != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (go) state <= ST_REQ;
        ST_REQ:  if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          left_q  <= mem_rsp_data[DW-1:SMP_W];
          right_q <= mem_rsp_data[SMP_W-1:0];
          state   <= ST_EMIT;
        end
        ST_EMIT: if (smp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      rate_q  <= '0;
      depth_q <= '0;
      irq     <= 1'b0;
    end else begin
      if (bus_wr && (bus_sel == RS_EN))    en_q    <= bus_wdata[0];
      if (bus_wr && (bus_sel == RS_RATE))  rate_q  <= bus_wdata[RATE_W-1:0];
      if (bus_wr && (bus_sel == RS_DEPTH)) depth_q <= bus_wdata[DEPTH_W-1:0];
      if (pop_raise)    irq <= 1'b1;
      else if (wr_stat) irq <= 1'b0;
    end
  end

  assign status = {q_count[1], (q_count != 2'd0), 4'b0, en_q, 1'b1, 3'b0, 1'b1,
                   19'b0, q_count[1]};
  assign bus_rdata     = (bus_sel == RS_STAT) ? status : 32'(head_len);
  assign mem_req_valid = (state == ST_REQ);
  assign smp_valid     = (state == ST_EMIT);
  assign smp_left      = left_q;
  assign smp_right     = right_q;
  assign smp_precision = {1'b0, depth_q} + (DEPTH_W+1)'(1);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  p_smp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_left) && $stable(smp_right));
  p_no_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && !(en_q && (q_count != 2'd0)) |=> !mem_req_valid);
  p_irq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && !pop_raise |=> !irq);
  p_adv_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (q_count != 2'd0));
endmodule

// File: tb/pcm_out_dma_tb.sv
module pcm_out_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_sel = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [23:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'd0;
  logic        smp_valid;
  logic        smp_ready = 1'b1;
  logic [15:0] smp_left, smp_right;
  logic [4:0]  smp_precision;
  logic        irq;

  logic mem_stall = 1'b0;
  int total = 0, bad = 0, cyc = 0;
  int n_smp = 0, n_req = 0;
  logic [15:0] rec_l [256];
  logic [15:0] rec_r [256];
  int          rec_t [256];
  bit done = 1'b0;

  localparam logic [31:0] ST_EMPTY = 32'h0110_0000;
  localparam logic [31:0] EN_BIT   = 32'h0200_0000;
  localparam logic [31:0] ONE_Q    = 32'h4000_0000;
  localparam logic [31:0] TWO_Q    = 32'hC000_0001;

  // rate, depth, raw address, raw length
  localparam logic [31:0] VEC [3][4] = '{
    '{32'd3, 32'd15, 32'hAB12_3457, 32'h00FC_0013},
    '{32'd0, 32'd7,  32'h0000_1FF8, 32'h0000_0010},
    '{32'd5, 32'd2,  32'h00FF_FFF8, 32'h0000_0010}
  };

  pcm_out_dma u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right), .smp_precision(smp_precision),
    .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [23:0] a);
    return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
  endfunction

  // memory model: one response the cycle after acceptance
  always @(posedge clk) begin
    mem_rsp_valid <= rst_n && mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem_word(mem_req_addr);
    mem_req_ready <= mem_stall ? ~mem_req_ready : 1'b1;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_valid) n_req <= n_req + 1;
    if (smp_valid && smp_ready && n_smp < 256) begin
      rec_l[n_smp] <= smp_left;
      rec_r[n_smp] <= smp_right;
      rec_t[n_smp] <= cyc;
      n_smp <= n_smp + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] v);
    bus_sel = sel;
    #1 v = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_ready = 1'b1; mem_stall = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_smp(input int upto);
    for (int i = 0; i < 5000 && n_smp < upto; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_smp(input int idx, input logic [23:0] a, input string tag);
    logic [31:0] w;
    w = mem_word(a);
    chk({rec_l[idx], rec_r[idx]} == w, tag, {rec_l[idx], rec_r[idx]}, w);
  endtask

  initial begin
    logic [31:0] v;
    int base;
    do_reset();
    // R1 reset state
    rd(3'd3, v);
    chk(v == ST_EMPTY, "R1 status", v, ST_EMPTY);
    chk(!irq && !mem_req_valid && !smp_valid, "R1 outputs", {irq, mem_req_valid, smp_valid}, 0);
    chk(smp_precision == 5'd1, "R7 reset precision", smp_precision, 1);

    // vector table
    for (int k = 0; k < 3; k++) begin
      logic [23:0] a;
      logic [10:0] hi;
      logic [12:0] lo;
      bit cy;
      int n, per;
      do_reset();
      wr(3'd4, VEC[k][0]);
      wr(3'd5, VEC[k][1]);
      chk(smp_precision == 5'(VEC[k][1][3:0]) + 5'd1, "R7 precision", smp_precision,
          5'(VEC[k][1][3:0]) + 5'd1);
      wr(3'd0, VEC[k][2]);
      wr(3'd1, VEC[k][3]);
      rd(3'd3, v);
      chk(v == (ST_EMPTY | ONE_Q), "R4 one queued", v, ST_EMPTY | ONE_Q);
      rd(3'd1, v);
      chk(v == (VEC[k][3] & 32'h3FFF8), "R3 length mask", v, VEC[k][3] & 32'h3FFF8);
      n = int'((VEC[k][3] & 32'h3FFF8) >> 2);
      per = 2 * (int'(VEC[k][0]) + 1) + 3;
      base = n_smp;
      wr(3'd2, 32'd1);
      rd(3'd3, v);
      chk(v == (ST_EMPTY | ONE_Q | EN_BIT), "R4 enable bit", v, ST_EMPTY | ONE_Q | EN_BIT);
      wait_smp(base + n);
      a = VEC[k][2][23:0] & 24'hFFFFF8;
      hi = a[23:13]; lo = a[12:0]; cy = 1'b0;
      for (int i = 0; i < n; i++) begin
        hi = hi + 11'(cy);
        chk_smp(base + i, {hi, lo}, "R8 R9 sample data");
        lo = lo + 13'd4;
        cy = (lo == 13'd0);
        if (i > 0)
          chk(rec_t[base+i] - rec_t[base+i-1] == per, "R6 sample spacing",
              rec_t[base+i] - rec_t[base+i-1], per);
      end
      rd(3'd3, v);
      chk(v == (ST_EMPTY | EN_BIT), "R10 drained", v, ST_EMPTY | EN_BIT);
      chk(!irq, "R10 no irq on last buffer", irq, 0);
    end

    // zero length rejected
    do_reset();
    wr(3'd1, 32'd4);
    wr(3'd1, 32'h0004_0000);
    rd(3'd3, v);
    chk(v == ST_EMPTY, "R3 zero length", v, ST_EMPTY);

    // queue full, switch, interrupt
    do_reset();
    wr(3'd0, 32'h200); wr(3'd1, 32'd8);
    wr(3'd0, 32'h400); wr(3'd1, 32'd8);
    rd(3'd3, v);
    chk(v == (ST_EMPTY | TWO_Q), "R4 two queued", v, ST_EMPTY | TWO_Q);
    wr(3'd0, 32'h600); wr(3'd1, 32'd24);
    rd(3'd3, v);
    chk(v == (ST_EMPTY | TWO_Q), "R3 full rejects", v, ST_EMPTY | TWO_Q);
    rd(3'd1, v);
    chk(v == 32'd8, "R3 head length", v, 8);
    base = n_smp;
    wr(3'd2, 32'd1);
    wait_smp(base + 2);
    chk(irq, "R10 irq on switch", irq, 1);
    rd(3'd3, v);
    chk(v == (ST_EMPTY | ONE_Q | EN_BIT), "R10 one left", v, ST_EMPTY | ONE_Q | EN_BIT);
    wr(3'd3, 32'd0);
    chk(!irq, "R5 irq cleared", irq, 0);
    wait_smp(base + 4);
    chk_smp(base, 24'h200, "R10 first buffer");
    chk_smp(base + 1, 24'h204, "R10 first buffer");
    chk_smp(base + 2, 24'h400, "R2 second address kept");
    chk_smp(base + 3, 24'h404, "R2 second address kept");
    chk(!irq, "R10 no irq when empty", irq, 0);

    // no fetch when disabled or empty
    do_reset();
    wr(3'd0, 32'h100); wr(3'd1, 32'd8);
    base = n_req;
    repeat (60) @(negedge clk);
    chk(n_req == base, "R11 disabled", n_req, base);
    do_reset();
    wr(3'd2, 32'd1);
    base = n_req;
    repeat (60) @(negedge clk);
    chk(n_req == base, "R11 empty", n_req, base);

    // back-pressure
    do_reset();
    mem_stall = 1'b1;
    smp_ready = 1'b0;
    wr(3'd0, 32'h340); wr(3'd1, 32'd8);
    base = n_smp;
    wr(3'd2, 32'd1);
    for (int i = 0; i < 200 && !smp_valid; i++) @(negedge clk);
    v = {smp_left, smp_right};
    repeat (10) @(negedge clk);
    chk(smp_valid && ({smp_left, smp_right} == v), "R12 sample held",
        {smp_left, smp_right}, v);
    chk(v == mem_word(24'h340), "R12 held value", v, mem_word(24'h340));
    smp_ready = 1'b1;
    wait_smp(base + 2);
    chk_smp(base + 1, 24'h344, "R12 after release");
    mem_stall = 1'b0;

    // concurrent last response and length write
    do_reset();
    wr(3'd4, 32'd1);
    wr(3'd0, 32'h100); wr(3'd1, 32'd8);
    wr(3'd0, 32'h800);
    base = n_smp;
    wr(3'd2, 32'd1);
    begin
      int seen = 0;
      for (int i = 0; i < 500 && seen < 2; i++) begin
        @(negedge clk);
        if (mem_rsp_valid) seen++;
      end
    end
    wr(3'd1, 32'd16);
    chk(irq, "R13 irq", irq, 1);
    rd(3'd3, v);
    chk(v == (ST_EMPTY | ONE_Q | EN_BIT), "R13 count", v, ST_EMPTY | ONE_Q | EN_BIT);
    rd(3'd1, v);
    chk(v == 32'd16, "R13 head length", v, 16);
    wait_smp(base + 6);
    chk_smp(base + 1, 24'h104, "R13 old buffer");
    for (int i = 0; i < 4; i++)
      chk_smp(base + 2 + i, 24'h800 + 24'(4 * i), "R13 new buffer");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule